// File: doc/BRIEF.md
# Receiver Idle Timeout Counter

This block watches the receive line of a serial port for silence. After a character arrives it counts bit periods. If a programmed number of bit periods pass with no further character, it raises a timeout flag. The flag stays set until software clears it. The receiver datapath supplies a one-cycle bit-period tick and a one-cycle strobe for each completed character. The timeout length, in bit periods, comes from a programmable value.

Two commands restart the counter in different ways:

- **Restart-now** reloads the period and starts counting at once. No character is needed.
- **Wait-for-character** stops any period in progress and clears the flag. Counting then resumes only when the next character arrives.

A programmed length of zero turns the whole function off.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `timeoutFlag` is 0 and `counting` is 0. The block waits for a character.
- R2: With a nonzero `toValue`, a `charRcvd` pulse makes `counting` 1 from the following cycle on.
- R3: After a load of value N, counting continues. On the clock edge that takes the N-th `bitTick`, `timeoutFlag` becomes 1 and `counting` becomes 0.
- R4: A `charRcvd` pulse while counting reloads the full `toValue`. The flag then needs N further ticks.
- R5: A `cmdRestart` pulse with a nonzero `toValue` reloads `toValue` and starts counting at once, in every state. It sets `counting` to 1 on the next cycle.
- R6: A `cmdWaitChar` pulse sets `counting` to 0 and `timeoutFlag` to 0 on the next cycle.
- R7: After `cmdWaitChar`, `bitTick` pulses have no effect until a `charRcvd` arrives. `counting` stays 0 and `timeoutFlag` stays 0.
- R8: `timeoutFlag` is sticky. It stays 1 through `bitTick`, `charRcvd` and `cmdRestart`. Only `cmdWaitChar` or reset clears it. After the flag sets, the counter stays idle until a character or `cmdRestart` rearms it.
- R9: While `toValue` is 0, `counting` is 0 on the next cycle. `charRcvd`, `cmdRestart` and `bitTick` have no effect, and the flag never sets. `cmdWaitChar` still clears the flag.
- R10: When `cmdWaitChar` arrives in the same cycle as `cmdRestart` or `charRcvd`, `cmdWaitChar` wins. The counter is left stopped.
- R11: The count changes only on cycles with `bitTick`. Cycles without a tick never bring the flag closer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One pulse per bit period |
| charRcvd | input | 1 | One pulse per received character |
| toValue | input | CNT_W | Timeout length in bit periods; 0 disables the block |
| cmdRestart | input | 1 | Reload and count immediately |
| cmdWaitChar | input | 1 | Stop, clear the flag, wait for a character |
| timeoutFlag | output | 1 | Sticky timeout flag |
| counting | output | 1 | High while a period is being counted |

## Verification
The bench targets the following corner cases:

- **Off-by-one at expiry.** A design that sets the flag one tick early or late fails the exact-N tick count.
- **Load colliding with a tick.** If the tick wins in that cycle, the counter loses a period.
- **Both commands in one cycle.** If the wait command does not win, the counter keeps running.
- **Ticks after the wait command.** A design that counts them sets the flag spuriously.
- **Flag persistence.** A design that clears the flag on restart or on a character loses a sticky event.
- **Zero length.** A design that does not handle zero underflows and counts for the full counter range.

A long random phase compares both outputs every cycle against a reference model.

// File: rtl/idle_pkg.sv
package idle_pkg;

  // Strobes from the control FSM to the count datapath
  typedef struct packed {
    logic load;     // reload counter from toValue
    logic dec;      // decrement on this bit tick
    logic clrFlag;  // clear the sticky flag
  } idleStrobe_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,  // waiting for a character
    ST_RUN  = 2'd1,  // counting bit periods
    ST_DONE = 2'd2   // expired, idle until rearmed
  } idleState_t;

endpackage

// File: rtl/idle_ctrl.sv
module idle_ctrl
  import idle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        charRcvd,
  input  logic        cmdRestart,
  input  logic        cmdWaitChar,
  input  logic        valZero,
  input  logic        lastTick,
  output idleStrobe_t strobes,
  output logic        counting
);

  idleState_t state, stateNxt;

  always_comb begin
    stateNxt        = state;
    strobes.load    = 1'b0;
    strobes.dec     = 1'b0;
    strobes.clrFlag = cmdWaitChar;
    if (valZero) begin
      stateNxt = ST_WAIT;
    end else if (cmdWaitChar) begin
      stateNxt = ST_WAIT;
    end else if (cmdRestart || charRcvd) begin
      stateNxt     = ST_RUN;
      strobes.load = 1'b1;
    end else if (state == ST_RUN && bitTick) begin
      strobes.dec = 1'b1;
      if (lastTick) stateNxt = ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNxt;
  end

  assign counting = (state == ST_RUN);

  // R6
  wait_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdWaitChar |=> !counting);

  // R9
  zero_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    valZero |=> !counting);

  // R5
  restart_runs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRestart && !cmdWaitChar && !valZero) |=> counting);

  // R7
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!counting && !charRcvd && !cmdRestart) |=> !counting);

endmodule

// File: rtl/idle_count.sv
module idle_count
  import idle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] toValue,
  input  idleStrobe_t      strobes,
  output logic             lastTick,
  output logic             timeoutFlag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign lastTick = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.load) begin
      cnt <= toValue;
    end else if (strobes.dec) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
    end else if (strobes.clrFlag) begin
      timeoutFlag <= 1'b0;
    end else if (strobes.dec && lastTick) begin
      timeoutFlag <= 1'b1;
    end
  end

  // R3
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dec && lastTick && !strobes.clrFlag) |=> timeoutFlag);

  // R11
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.dec) |=> $stable(cnt));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !strobes.clrFlag) |=> timeoutFlag);

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import idle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             charRcvd,
  input  logic [CNT_W-1:0] toValue,
  input  logic             cmdRestart,
  input  logic             cmdWaitChar,
  output logic             timeoutFlag,
  output logic             counting
);

  idleStrobe_t strobes;
  logic        lastTick;
  logic        valZero;

  assign valZero = (toValue == '0);

  idle_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bitTick     (bitTick),
    .charRcvd    (charRcvd),
    .cmdRestart  (cmdRestart),
    .cmdWaitChar (cmdWaitChar),
    .valZero     (valZero),
    .lastTick    (lastTick),
    .strobes     (strobes),
    .counting    (counting)
  );

  idle_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rstN        (rstN),
    .toValue     (toValue),
    .strobes     (strobes),
    .lastTick    (lastTick),
    .timeoutFlag (timeoutFlag)
  );

endmodule

// File: tb/sim_rx_idle_timeout.sv
`timescale 1ns/1ps
module sim_rx_idle_timeout;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 0, charRcvd = 0, cmdRestart = 0, cmdWaitChar = 0;
  logic [W-1:0] toValue = '0;
  logic timeoutFlag, counting;

  int total = 0, bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  rx_idle_timeout #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .charRcvd(charRcvd),
    .toValue(toValue), .cmdRestart(cmdRestart), .cmdWaitChar(cmdWaitChar),
    .timeoutFlag(timeoutFlag), .counting(counting)
  );

  // Reference model built from the requirements
  int mState = 0;  // 0 wait, 1 run, 2 done
  int mCnt = 0;
  bit mFlag = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mFlag = 0;
    end else begin
      if (cmdWaitChar) mFlag = 0;
      if (toValue == 0) mState = 0;
      else if (cmdWaitChar) mState = 0;
      else if (cmdRestart || charRcvd) begin mState = 1; mCnt = toValue; end
      else if (mState == 1 && bitTick) begin
        if (mCnt == 1) begin mFlag = 1; mState = 2; end
        mCnt = mCnt - 1;
      end
    end
  end

  function automatic bit expCounting(); return mState == 1; endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic c, input logic r, input logic w);
    bitTick = t; charRcvd = c; cmdRestart = r; cmdWaitChar = w;
    @(posedge clk);
    @(negedge clk);
    bitTick = 0; charRcvd = 0; cmdRestart = 0; cmdWaitChar = 0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flag", timeoutFlag, 1'b0);
    check("R1 counting", counting, 1'b0);

    toValue = 3;
    step(1, 0, 0, 0);
    check("R7 tick before char", counting, 1'b0);
    step(1, 1, 0, 0);  // load wins over tick
    check("R2 counting", counting, 1'b1);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    check("R11 no tick no flag", timeoutFlag, 1'b0);
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    check("R3 before Nth tick", timeoutFlag, 1'b0);
    step(1, 1, 0, 0);  // reload at tick 3
    check("R4 reload no flag", timeoutFlag, 1'b0);
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    check("R4 still counting", counting, 1'b1);
    step(1, 0, 0, 0);
    check("R3 flag at Nth tick", timeoutFlag, 1'b1);
    check("R3 counting off", counting, 1'b0);
    step(1, 0, 0, 0);
    check("R8 sticky over tick", timeoutFlag, 1'b1);
    check("R8 idle after expiry", counting, 1'b0);
    step(0, 0, 1, 0);
    check("R8 sticky over restart", timeoutFlag, 1'b1);
    check("R5 restart counts", counting, 1'b1);
    step(0, 0, 0, 1);
    check("R6 flag cleared", timeoutFlag, 1'b0);
    check("R6 stopped", counting, 1'b0);
    repeat (5) step(1, 0, 0, 0);
    check("R7 ticks ignored flag", timeoutFlag, 1'b0);
    check("R7 ticks ignored counting", counting, 1'b0);
    step(0, 1, 1, 1);
    check("R10 wait wins", counting, 1'b0);
    toValue = 0;
    step(1, 1, 1, 0);
    repeat (4) step(1, 0, 0, 0);
    check("R9 zero no counting", counting, 1'b0);
    check("R9 zero no flag", timeoutFlag, 1'b0);
    toValue = 1;
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    check("R3 N=1 flag", timeoutFlag, 1'b1);

    // Constrained random phase against the model
    for (int i = 0; i < 20000; i++) begin
      int p;
      p = $urandom_range(0, 99);
      if ($urandom_range(0, 199) == 0) toValue = (p < 20) ? 0 : W'($urandom_range(1, 6));
      bitTick = ($urandom_range(0, 2) != 0);
      charRcvd = ($urandom_range(0, 14) == 0);
      cmdRestart = ($urandom_range(0, 39) == 0);
      cmdWaitChar = ($urandom_range(0, 39) == 0);
      @(posedge clk);
      @(negedge clk);
      check("R3 random flag", timeoutFlag, mFlag);
      check("R2 random counting", counting, expCounting());
    end
    bitTick = 0; charRcvd = 0; cmdRestart = 0; cmdWaitChar = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule